// File: doc/BRIEF.md
# Serial Double-Buffered DAC Front End

This block is the digital side of a serially programmed 10-bit converter. A host writes 16-bit command words over a three-wire link: an active-low select, a serial clock and a data line. The three wires are resynchronised into the system clock domain. Bits are captured on each rising serial-clock edge while the select is low. The word is judged only when the select returns high. A word of exactly sixteen bits is decoded. A word of any other length is dropped, and a one-cycle error pulse marks the drop.

Two code registers sit behind the link. The staging register takes new data without disturbing the output. The output register drives the converter code. A command can load one register, load both, or copy staging into output. A power-down command makes the output high-impedance and keeps both registers intact. Copying staging into output also leaves power-down, so the previous output level can be restored. A settle flag stays low for a programmable number of system clocks after reset and after each exit from power-down.

Top module: `sdac_front`

## Requirements
- R1: After reset the output code and the staging register are zero, the shutdown flag is low, the output enable is high and the settle flag is low.
- R2: A word is taken MSB first. Its bits 15:13 are the command, bits 12:3 are the 10-bit code with bit 12 as the code MSB, and bits 2:0 are ignored.
- R3: Command 3'b010 loads the code into both registers and clears shutdown.
- R4: Command 3'b001 loads the staging register only, and the output code stays unchanged.
- R5: Command 3'b101 copies the staging register into the output register and clears shutdown.
- R6: Command 3'b111 sets shutdown, drives the output enable low and leaves both registers unchanged.
- R7: Commands 3'b000, 3'b011, 3'b100 and 3'b110 change nothing.
- R8: If the select rises after any bit count other than 16, no register changes and the frame error output is high for exactly one clock.
- R9: Serial-clock edges while the select is high capture nothing and do not disturb the next frame.
- R10: A frame sent as two 8-bit bursts with a pause between them, with the select held low throughout, is accepted.
- R11: The settle flag is low while in shutdown. It is also low for SETTLE_CYCLES clocks after reset or after leaving shutdown, and high afterwards.
- R12: A final serial-clock rise seen in the same sampled cycle as the select rise still counts as a bit of the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Serial select, active low, asynchronous |
| sclk | input | 1 | Serial clock, asynchronous |
| din | input | 1 | Serial data, asynchronous |
| dac_code | output | 10 | Code presented to the converter |
| shut_o | output | 1 | High while in shutdown |
| out_en | output | 1 | Output amplifier enable; low means high-impedance |
| frame_err | output | 1 | One-clock pulse when a frame of the wrong length is discarded |
| settle_ok | output | 1 | High once the output has had time to settle |

## Verification
The capture of a data bit and the end-of-frame judgement can fall in the same system cycle. This happens when the last serial-clock rise and the select rise reach the synchroniser together. The bench provokes this by driving both pins on the same clock. It expects the frame to be counted as sixteen bits and executed, and it expects no error pulse. The same judgement is also exercised with the two edges well apart. Random frames of both kinds, and frames of wrong length, are compared against a bench model of both registers and of the shutdown state.

// File: rtl/sdac_pkg.sv
// Shared widths and command codes for the serial DAC front end.
// Assumes a 3-bit command, a 10-bit code and 3 trailing pad bits.
package sdac_pkg;
    localparam int CTRL_W = 3;
    localparam int CODE_W = 10;
    localparam int PAD_W  = 3;
    localparam int WORD_W = CTRL_W + CODE_W + PAD_W;

    localparam logic [CTRL_W-1:0] CMD_LOAD_IN   = 3'b001;
    localparam logic [CTRL_W-1:0] CMD_LOAD_BOTH = 3'b010;
    localparam logic [CTRL_W-1:0] CMD_XFER      = 3'b101;
    localparam logic [CTRL_W-1:0] CMD_SHUT      = 3'b111;
endpackage

// File: rtl/sdac_sync.sv
// Multi-stage synchroniser for a vector of asynchronous single-bit inputs.
// Assumes each bit is independent; reset loads RST_VAL so idle levels hold.
module sdac_sync #(
    parameter int              WIDTH   = 3,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            // One flop rank of the synchroniser chain.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stg[s] <= RST_VAL;
                end else if (s == 0) begin
                    stg[s] <= d;
                end else begin
                    stg[s] <= stg[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/sdac_shifter.sv
// Serial capture: detects serial-clock rises and select rises on synchronised
// inputs, shifts bits MSB first, and judges the bit count when select rises.
// Assumes the serial clock is slower than half the system clock after sync.
module sdac_shifter
    import sdac_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_s,
    input  logic              sclk_s,
    input  logic              din_s,
    output logic              frame_ok,
    output logic              frame_err,
    output logic [CTRL_W-1:0] frame_ctrl,
    output logic [CODE_W-1:0] frame_code
);
    localparam int                CNT_W    = $clog2(WORD_W + 2);
    localparam logic [CNT_W-1:0]  CNT_FULL = CNT_W'(WORD_W);
    localparam logic [CNT_W-1:0]  CNT_SAT  = CNT_W'(WORD_W + 1);

    logic              sclk_d, cs_d;
    logic              shift_en, cs_rise;
    logic [CNT_W-1:0]  cnt, cnt_nx;
    logic [WORD_W-1:0] shreg, sh_nx;

    // Edge detection and next shift/count values, including a bit that
    // arrives in the same cycle as the select rise.
    always_comb begin
        shift_en = sclk_s & ~sclk_d & ~cs_d;
        cs_rise  = cs_s & ~cs_d;
        cnt_nx   = cnt;
        sh_nx    = shreg;
        if (shift_en) begin
            sh_nx = {shreg[WORD_W-2:0], din_s};
            if (cnt != CNT_SAT) begin
                cnt_nx = cnt + 1'b1;
            end
        end
    end

    // Shift register, saturating bit counter and end-of-frame verdict.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_d     <= 1'b0;
            cs_d       <= 1'b1;
            cnt        <= '0;
            shreg      <= '0;
            frame_ok   <= 1'b0;
            frame_err  <= 1'b0;
            frame_ctrl <= '0;
            frame_code <= '0;
        end else begin
            sclk_d    <= sclk_s;
            cs_d      <= cs_s;
            frame_ok  <= 1'b0;
            frame_err <= 1'b0;
            shreg     <= sh_nx;
            cnt       <= cs_s ? '0 : cnt_nx;
            if (cs_rise) begin
                if (cnt_nx == CNT_FULL) begin
                    frame_ok   <= 1'b1;
                    frame_ctrl <= sh_nx[WORD_W-1 -: CTRL_W];
                    frame_code <= sh_nx[PAD_W +: CODE_W];
                end else begin
                    frame_err  <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/sdac_regs.sv
// Double-buffered code registers and shutdown state, updated by decoded
// commands. Assumes frame_ok is a single-cycle strobe with stable fields.
module sdac_regs
    import sdac_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_ok,
    input  logic [CTRL_W-1:0] frame_ctrl,
    input  logic [CODE_W-1:0] frame_code,
    output logic [CODE_W-1:0] dac_q,
    output logic              shut_q
);
    logic [CODE_W-1:0] stage_q;

    // Command execution on each accepted frame; unlisted codes are no-ops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
            dac_q   <= '0;
            shut_q  <= 1'b0;
        end else if (frame_ok) begin
            case (frame_ctrl)
                CMD_LOAD_BOTH: begin
                    stage_q <= frame_code;
                    dac_q   <= frame_code;
                    shut_q  <= 1'b0;
                end
                CMD_LOAD_IN: begin
                    stage_q <= frame_code;
                end
                CMD_XFER: begin
                    dac_q  <= stage_q;
                    shut_q <= 1'b0;
                end
                CMD_SHUT: begin
                    shut_q <= 1'b1;
                end
                default: begin
                end
            endcase
        end
    end
endmodule

// File: rtl/sdac_settle.sv
// Settling timer: held full while shut down, counts down otherwise; the
// flag is high only when awake and the count has reached zero.
module sdac_settle #(
    parameter int SETTLE_CYCLES = 2500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic shut,
    output logic settle_ok
);
    localparam int             CW   = (SETTLE_CYCLES < 1) ? 1 : $clog2(SETTLE_CYCLES + 1);
    localparam logic [CW-1:0]  LOAD = CW'(SETTLE_CYCLES);

    logic [CW-1:0] cnt;

    // Reload during reset or shutdown, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n || shut) begin
            cnt <= LOAD;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign settle_ok = !shut && (cnt == '0);
endmodule

// File: rtl/sdac_front.sv
// Top of the serial DAC front end: synchronises the three-wire link,
// captures 16-bit frames, executes commands and times output settling.
// Assumes all serial pins are asynchronous to clk.
module sdac_front
    import sdac_pkg::*;
#(
    parameter int SYNC_STAGES   = 2,
    parameter int SETTLE_CYCLES = 2500
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              din,
    output logic [CODE_W-1:0] dac_code,
    output logic              shut_o,
    output logic              out_en,
    output logic              frame_err,
    output logic              settle_ok
);
    logic [2:0]        pins_s;
    logic              frame_ok;
    logic [CTRL_W-1:0] frame_ctrl;
    logic [CODE_W-1:0] frame_code;

    sdac_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({cs_n, sclk, din}), .q(pins_s)
    );

    sdac_shifter u_shift (
        .clk(clk), .rst_n(rst_n),
        .cs_s(pins_s[2]), .sclk_s(pins_s[1]), .din_s(pins_s[0]),
        .frame_ok(frame_ok), .frame_err(frame_err),
        .frame_ctrl(frame_ctrl), .frame_code(frame_code)
    );

    sdac_regs u_regs (
        .clk(clk), .rst_n(rst_n), .frame_ok(frame_ok),
        .frame_ctrl(frame_ctrl), .frame_code(frame_code),
        .dac_q(dac_code), .shut_q(shut_o)
    );

    sdac_settle #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
        .clk(clk), .rst_n(rst_n), .shut(shut_o), .settle_ok(settle_ok)
    );

    assign out_en = ~shut_o;
endmodule

// Checker for sdac_front, attached by bind below.
module sdac_front_chk
    import sdac_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              frame_ok,
    input logic              frame_err,
    input logic [CODE_W-1:0] dac_code,
    input logic              shut_o,
    input logic              settle_ok
);
    a_r8_err_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |=> !frame_err);

    a_r8_err_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |=> ($stable(dac_code) && $stable(shut_o)));

    a_r8_verdict_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(frame_ok && frame_err));

    a_r4_code_moves_on_frame: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dac_code) |-> $past(frame_ok));

    a_r6_shut_enters_on_frame: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(shut_o) |-> $past(frame_ok));

    a_r11_low_in_shutdown: assert property (@(posedge clk) disable iff (!rst_n)
        shut_o |-> !settle_ok);

    a_r11_low_after_wake: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(shut_o) |-> !settle_ok);
endmodule

bind sdac_front sdac_front_chk u_chk (
    .clk(clk), .rst_n(rst_n), .frame_ok(frame_ok), .frame_err(frame_err),
    .dac_code(dac_code), .shut_o(shut_o), .settle_ok(settle_ok)
);

// File: tb/tb_sdac_front.sv
`timescale 1ns/1ps
module tb_sdac_front;
    localparam int SETTLE = 64;

    logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sclk = 1'b0, din = 1'b0;
    logic [9:0] dac_code;
    logic shut_o, out_en, frame_err, settle_ok;

    int checks = 0, fails = 0, err_seen = 0;
    logic [9:0] m_in = '0, m_dac = '0;
    logic       m_shut = 1'b0;

    sdac_front #(.SYNC_STAGES(2), .SETTLE_CYCLES(SETTLE)) dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
        .dac_code(dac_code), .shut_o(shut_o), .out_en(out_en),
        .frame_err(frame_err), .settle_ok(settle_ok)
    );

    always #4 clk = ~clk;

    always @(negedge clk) if (frame_err) err_seen++;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] mk(input logic [2:0] c, input logic [9:0] code, input logic [2:0] pad);
        return {c, code, pad};
    endfunction

    function automatic void model(input logic [15:0] w);
        case (w[15:13])
            3'b010: begin m_in = w[12:3]; m_dac = w[12:3]; m_shut = 1'b0; end
            3'b001: m_in = w[12:3];
            3'b101: begin m_dac = m_in; m_shut = 1'b0; end
            3'b111: m_shut = 1'b1;
            default: ;
        endcase
    endfunction

    task automatic send(input logic [15:0] w, input int nbits, input bit split, input bit tie_end);
        cs_n = 1'b0;
        tick(4);
        for (int i = 0; i < nbits; i++) begin
            din = w[15 - (i % 16)];
            tick(3);
            sclk = 1'b1;
            if (tie_end && i == nbits - 1) cs_n = 1'b1;
            tick(3);
            sclk = 1'b0;
            if (split && i == 7) tick(20);
        end
        tick(2);
        cs_n = 1'b1;
        tick(10);
    endtask

    task automatic frame(input string req, input logic [15:0] w, input int nbits,
                         input bit split, input bit tie_end);
        int e0;
        e0 = err_seen;
        send(w, nbits, split, tie_end);
        if (nbits == 16) model(w);
        chk({req, " code"}, 32'(dac_code), 32'(m_dac));
        chk({req, " shut"}, 32'(shut_o), 32'(m_shut));
        chk({req, " oe"}, 32'(out_en), 32'(!m_shut));
        chk({req, " err"}, 32'(err_seen - e0), (nbits == 16) ? 32'd0 : 32'd1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        tick(5);
        rst_n = 1'b1;
        tick(2);
        // R1 reset state
        chk("R1 code", 32'(dac_code), 32'h0);
        chk("R1 shut", 32'(shut_o), 32'h0);
        chk("R1 oe", 32'(out_en), 32'h1);
        chk("R11 settle after reset", 32'(settle_ok), 32'h0);
        tick(SETTLE + 5);
        chk("R11 settle done", 32'(settle_ok), 32'h1);
        // R1 staging register is zero: transfer keeps code at zero
        frame("R1 staging", mk(3'b101, 10'h3ff, 3'b000), 16, 0, 0);
        // R2/R3 load both, pad bits ignored
        frame("R2 R3 load both", mk(3'b010, 10'h2a5, 3'b101), 16, 0, 0);
        // R4 load staging only
        frame("R4 load staging", mk(3'b001, 10'h155, 3'b000), 16, 0, 0);
        // R6 shutdown keeps registers
        frame("R6 shutdown", mk(3'b111, 10'h0ff, 3'b111), 16, 0, 0);
        chk("R11 low in shutdown", 32'(settle_ok), 32'h0);
        // R5 transfer leaves shutdown and restores staged value
        frame("R5 transfer", mk(3'b101, 10'h000, 3'b000), 16, 0, 0);
        chk("R11 low after wake", 32'(settle_ok), 32'h0);
        tick(SETTLE + 5);
        chk("R11 high after wake", 32'(settle_ok), 32'h1);
        // R7 no-op codes
        frame("R7 nop 000", mk(3'b000, 10'h3ff, 3'b000), 16, 0, 0);
        frame("R7 nop 011", mk(3'b011, 10'h3ff, 3'b000), 16, 0, 0);
        frame("R7 nop 100", mk(3'b100, 10'h3ff, 3'b000), 16, 0, 0);
        frame("R7 nop 110", mk(3'b110, 10'h3ff, 3'b000), 16, 0, 0);
        frame("R5 staging kept", mk(3'b101, 10'h000, 3'b000), 16, 0, 0);
        // R8 wrong lengths
        frame("R8 len15", mk(3'b010, 10'h001, 3'b000), 15, 0, 0);
        frame("R8 len17", mk(3'b010, 10'h002, 3'b000), 17, 0, 0);
        frame("R8 len8", mk(3'b010, 10'h003, 3'b000), 8, 0, 0);
        // R9 clocks with select high are ignored
        begin
            int e0;
            e0 = err_seen;
            for (int i = 0; i < 10; i++) begin
                din = i[0]; tick(3); sclk = 1'b1; tick(3); sclk = 1'b0;
            end
            tick(10);
            chk("R9 no err", 32'(err_seen - e0), 32'h0);
            chk("R9 code", 32'(dac_code), 32'(m_dac));
        end
        frame("R9 next frame", mk(3'b010, 10'h0f0, 3'b000), 16, 0, 0);
        // R10 two bursts
        frame("R10 split", mk(3'b010, 10'h3c3, 3'b000), 16, 1, 0);
        // R12 last clock rise together with select rise
        frame("R12 tied end", mk(3'b010, 10'h111, 3'b000), 16, 0, 1);
        // R3 load both leaves shutdown
        frame("R6 shut again", mk(3'b111, 10'h000, 3'b000), 16, 0, 0);
        frame("R3 wake by load", mk(3'b010, 10'h222, 3'b000), 16, 0, 0);
        // Random mix, checked against the model
        for (int n = 0; n < 80; n++) begin
            logic [15:0] w;
            int nb;
            w  = 16'($urandom);
            nb = ($urandom % 10 == 0) ? ((($urandom % 2) == 0) ? 15 : 17) : 16;
            frame("R2 random", w, nb, 1'($urandom % 2), 1'($urandom % 2));
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule